// File: doc/BRIEF.md
# GPIO Interrupt Detector with Glitch Filter

This block is the interrupt front end of a GPIO unit. It takes up to 24 raw, asynchronous pin signals and gives one interrupt request per line to a parent interrupt controller. Software sets each line through three per-line bit registers: a mask, a mode select and a filter enable. It also writes one filter period value that all lines share.

Each raw line first passes through a two-flop synchroniser. A line in level mode hands its synchronised level to the parent unchanged, and the parent applies its own sensing. A line in both-edge mode reports every change of its filtered value as a one-cycle pulse. That filtered value exists only when the line's filter is enabled. A filtered line accepts a new value only after the synchronised input has held that value for the shared period. The four registers sit on a simple write/read port at fixed offsets. The offsets match the space the surrounding GPIO register file leaves for them.

Top module: `gpio_irq_top`

## Requirements
- R1: Register offsets: mask at 0x90, mode at 0x94, filter enable at 0x98, shared period at 0x9C. Bit i of the first three belongs to line i, over bits 0 to 23. The period takes the low 8 bits of the write data. Unused upper bits read as 0. Any other offset reads as 0, and a write to it changes nothing.
- R2: After reset, the mask, mode and filter-enable registers read 0, the period reads 0xFF, and every output is 0.
- R3: A line with mask 1 and mode 0 drives its output with the raw input after two flops. A change sampled at one rising edge is visible after the second rising edge. The filter never alters this path, even when the line's filter is enabled.
- R4: A line with mask 0 drives 0 in every mode.
- R5: In mode 1 with the filter enabled, the filtered value takes a new level only after the synchronised input has differed from it for P consecutive cycles, where P is the period (0 counts as 1). A shorter excursion leaves no trace.
- R6: In mode 1 with the filter enabled, each change of the filtered value gives a pulse exactly one cycle wide. For an input changed between edges N and N+1, the pulse is high in the cycle after edge N+2+P.
- R7: In mode 1 with the filter disabled, the line's output stays 0 whatever its input does.
- R8: One period register sets the filter time of every filtered line at once. A new value applies to all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| lineIn | input | 24 | Raw GPIO lines, asynchronous |
| irqOut | output | 24 | Per-line request to the parent controller |

## Verification
The bench times the filter to the cycle. It checks that the both-edge pulse arrives exactly P cycles after synchronisation. An off-by-one counter compare shows up as a pulse one cycle early or late. A glitch exactly one cycle shorter than the period must vanish, so a filter that triggers on P-1 matching samples fails here. A one-cycle pulse on a level-mode line whose filter is enabled must still pass through. A design that routed level mode through the filter would swallow that pulse. Two further cases catch other faults: a both-edge line with the filter off must stay silent, and two filtered lines must fire in the same cycle after a single period write, which fails if the period is not truly shared.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  // Byte offsets of the interrupt registers inside the GPIO space
  localparam logic [7:0] OFS_MASK   = 8'h90;
  localparam logic [7:0] OFS_MODE   = 8'h94;
  localparam logic [7:0] OFS_FILTER = 8'h98;
  localparam logic [7:0] OFS_PERIOD = 8'h9C;

  // Write strobes from the control to the datapath
  typedef struct packed {
    logic maskWr;
    logic modeWr;
    logic filterWr;
    logic periodWr;
  } regStrobe_t;
endpackage

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 24,
  parameter int PERW   = 8,
  parameter int DATAW  = 32,
  parameter int ADDRW  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWe,
  input  logic [ADDRW-1:0] regAddr,
  input  logic [NLINES-1:0] maskQ,
  input  logic [NLINES-1:0] modeQ,
  input  logic [NLINES-1:0] filterQ,
  input  logic [PERW-1:0]   periodQ,
  output regStrobe_t       stb,
  output logic [DATAW-1:0] regRdata
);
  localparam int LPAD = DATAW - NLINES;
  localparam int PPAD = DATAW - PERW;

  logic hitMask, hitMode, hitFilter, hitPeriod;

  always_comb begin
    hitMask   = (regAddr == ADDRW'(OFS_MASK));
    hitMode   = (regAddr == ADDRW'(OFS_MODE));
    hitFilter = (regAddr == ADDRW'(OFS_FILTER));
    hitPeriod = (regAddr == ADDRW'(OFS_PERIOD));
    stb.maskWr   = regWe && hitMask;
    stb.modeWr   = regWe && hitMode;
    stb.filterWr = regWe && hitFilter;
    stb.periodWr = regWe && hitPeriod;
  end

  always_comb begin
    regRdata = '0;
    if (hitMask)   regRdata = {{LPAD{1'b0}}, maskQ};
    if (hitMode)   regRdata = {{LPAD{1'b0}}, modeQ};
    if (hitFilter) regRdata = {{LPAD{1'b0}}, filterQ};
    if (hitPeriod) regRdata = {{PPAD{1'b0}}, periodQ};
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.maskWr, stb.modeWr, stb.filterWr, stb.periodWr})); // R1
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !regWe |-> (stb == '0)); // R1
endmodule

// File: rtl/gpio_irq_dp.sv
module gpio_irq_dp
  import gpio_irq_pkg::*;
#(
  parameter int              NLINES    = 24,
  parameter int              PERW      = 8,
  parameter int              DATAW     = 32,
  parameter logic [PERW-1:0] PER_RESET = 8'hFF
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        stb,
  input  logic [DATAW-1:0]  regWdata,
  input  logic [NLINES-1:0] lineIn,
  output logic [NLINES-1:0] maskQ,
  output logic [NLINES-1:0] modeQ,
  output logic [NLINES-1:0] filterQ,
  output logic [PERW-1:0]   periodQ,
  output logic [NLINES-1:0] irqOut
);
  logic [NLINES-1:0] metaQ, syncQ, filtQ, pulseQ;
  logic [PERW-1:0]   effPeriod;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ   <= '0;
      modeQ   <= '0;
      filterQ <= '0;
      periodQ <= PER_RESET;
    end else begin
      if (stb.maskWr)   maskQ   <= regWdata[NLINES-1:0];
      if (stb.modeWr)   modeQ   <= regWdata[NLINES-1:0];
      if (stb.filterWr) filterQ <= regWdata[NLINES-1:0];
      if (stb.periodWr) periodQ <= regWdata[PERW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      metaQ <= '0;
      syncQ <= '0;
    end else begin
      metaQ <= lineIn;
      syncQ <= metaQ;
    end
  end

  assign effPeriod = (periodQ == '0) ? PERW'(1) : periodQ;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic [PERW-1:0] cntQ;
    logic [PERW:0]   cntNext;
    logic            differs, settle;

    always_comb begin
      cntNext = {1'b0, cntQ} + 1'b1;
      differs = syncQ[i] ^ filtQ[i];
      settle  = differs && (cntNext >= {1'b0, effPeriod});
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ      <= '0;
        filtQ[i]  <= 1'b0;
        pulseQ[i] <= 1'b0;
      end else if (!filterQ[i]) begin
        cntQ      <= '0;
        filtQ[i]  <= syncQ[i];
        pulseQ[i] <= 1'b0;
      end else if (!differs) begin
        cntQ      <= '0;
        pulseQ[i] <= 1'b0;
      end else if (settle) begin
        cntQ      <= '0;
        filtQ[i]  <= syncQ[i];
        pulseQ[i] <= 1'b1;
      end else begin
        cntQ      <= cntNext[PERW-1:0];
        pulseQ[i] <= 1'b0;
      end
    end
  end

  assign irqOut = maskQ & ((~modeQ & syncQ) | (modeQ & pulseQ));

  AST_FILT_TAKES_INPUT: assert property (@(posedge clk) disable iff (!rstN)
    ((filtQ ^ $past(filtQ)) & (filtQ ^ $past(syncQ))) == '0); // R5
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (periodQ > PERW'(1)) |=> ((pulseQ & $past(pulseQ)) == '0)); // R6
  AST_NO_UNFILTERED_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (irqOut & modeQ & ~$past(filterQ)) == '0); // R7
  AST_PERIOD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !stb.periodWr |=> $stable(periodQ)); // R8
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NLINES = 24,
  parameter int PERW   = 8,
  parameter int DATAW  = 32,
  parameter int ADDRW  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDRW-1:0]  regAddr,
  input  logic [DATAW-1:0]  regWdata,
  output logic [DATAW-1:0]  regRdata,
  input  logic [NLINES-1:0] lineIn,
  output logic [NLINES-1:0] irqOut
);
  regStrobe_t        stb;
  logic [NLINES-1:0] maskQ, modeQ, filterQ;
  logic [PERW-1:0]   periodQ;

  gpio_irq_ctrl #(.NLINES(NLINES), .PERW(PERW), .DATAW(DATAW), .ADDRW(ADDRW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .maskQ(maskQ), .modeQ(modeQ), .filterQ(filterQ), .periodQ(periodQ),
    .stb(stb), .regRdata(regRdata)
  );

  gpio_irq_dp #(.NLINES(NLINES), .PERW(PERW), .DATAW(DATAW), .PER_RESET(PERW'(8'hFF))) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .regWdata(regWdata), .lineIn(lineIn),
    .maskQ(maskQ), .modeQ(modeQ), .filterQ(filterQ), .periodQ(periodQ),
    .irqOut(irqOut)
  );
endmodule

// File: tb/sim_gpio_irq_top.sv
module sim_gpio_irq_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic [23:0] lineIn = '0;
  logic [23:0] irqOut;

  always #4 clk = ~clk;

  gpio_irq_top u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .lineIn(lineIn), .irqOut(irqOut)
  );

  typedef struct {
    int    cyc;
    int    line;
    bit    val;
    string req;
  } expItem_t;

  expItem_t sb[$];
  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // Monitor: compare every due scoreboard item
  always @(negedge clk) begin
    for (int k = sb.size() - 1; k >= 0; k--) begin
      if (sb[k].cyc <= cyc) begin
        check(sb[k].cyc == cyc && irqOut[sb[k].line] == sb[k].val,
              $sformatf("%s line%0d", sb[k].req, sb[k].line),
              {31'b0, irqOut[sb[k].line]}, {31'b0, sb[k].val});
        sb.delete(k);
      end
    end
  end

  task automatic expectAt(input int delta, input int line, input bit val, input string req);
    expItem_t it;
    it.cyc = cyc + delta; it.line = line; it.val = val; it.req = req;
    sb.push_back(it);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [7:0] a, input logic [31:0] d);
    regAddr = a; regWdata = d; regWe = 1'b1;
    tick(1);
    regWe = 1'b0;
  endtask

  task automatic regCheck(input logic [7:0] a, input logic [31:0] exp, input string req);
    regAddr = a;
    #1;
    check(regRdata == exp, req, regRdata, exp);
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    tick(3);
    // R2 reset state
    regCheck(8'h90, 32'h0, "R2 mask reset");
    regCheck(8'h94, 32'h0, "R2 mode reset");
    regCheck(8'h98, 32'h0, "R2 filter reset");
    regCheck(8'h9C, 32'hFF, "R2 period reset");
    check(irqOut == '0, "R2 outputs reset", {8'b0, irqOut}, 32'h0);
    rstN = 1'b1;
    tick(2);

    // R1 map, width and unmapped offsets
    regWrite(8'h90, 32'hFFFF_FFFF);
    regCheck(8'h90, 32'h00FF_FFFF, "R1 mask width");
    regWrite(8'h9C, 32'h0000_1234);
    regCheck(8'h9C, 32'h34, "R1 period width");
    regWrite(8'h8C, 32'hFFFF_FFFF);
    regCheck(8'h8C, 32'h0, "R1 unmapped read");
    regCheck(8'h94, 32'h0, "R1 unmapped write ignored");
    regCheck(8'h98, 32'h0, "R1 unmapped write ignored");

    // lines 0,2..6 unmasked, line1 masked; 4,5,6 both-edge; filter on 2,4,6
    regWrite(8'h90, 32'h7D);
    regWrite(8'h94, 32'h70);
    regWrite(8'h98, 32'h54);
    regWrite(8'h9C, 32'h4);
    regCheck(8'h98, 32'h54, "R1 filter readback");
    tick(4);

    // R3 level path, R4 masked line
    lineIn[0] = 1'b1; lineIn[1] = 1'b1;
    expectAt(1, 0, 1'b0, "R3 sync delay");
    expectAt(2, 0, 1'b1, "R3 level passes");
    expectAt(2, 1, 1'b0, "R4 masked");
    expectAt(6, 1, 1'b0, "R4 masked");
    tick(8);
    lineIn[0] = 1'b0;
    expectAt(2, 0, 1'b0, "R3 level falls");
    tick(6);
    // R3 one-cycle pulse on filtered-enabled level line passes unfiltered
    lineIn[2] = 1'b1;
    expectAt(2, 2, 1'b1, "R3 filter bypassed");
    tick(1);
    lineIn[2] = 1'b0;
    expectAt(2, 2, 1'b0, "R3 filter bypassed");
    tick(8);

    // R5/R6 both-edge filtered with P=4: rise then fall
    lineIn[4] = 1'b1;
    expectAt(5, 4, 1'b0, "R6 not early");
    expectAt(6, 4, 1'b1, "R6 rise pulse");
    expectAt(7, 4, 1'b0, "R6 one cycle");
    tick(12);
    lineIn[4] = 1'b0;
    expectAt(5, 4, 1'b0, "R6 not early");
    expectAt(6, 4, 1'b1, "R6 fall pulse");
    expectAt(7, 4, 1'b0, "R6 one cycle");
    tick(12);

    // R5 glitch of P-1 cycles is dropped
    lineIn[4] = 1'b1;
    for (int k = 1; k <= 12; k++) expectAt(k, 4, 1'b0, "R5 glitch dropped");
    tick(3);
    lineIn[4] = 1'b0;
    tick(14);

    // R7 both-edge without filter stays silent
    lineIn[5] = 1'b1;
    for (int k = 1; k <= 10; k++) expectAt(k, 5, 1'b0, "R7 no filter no event");
    tick(5);
    lineIn[5] = 1'b0;
    tick(12);

    // R8 shared period: P=6 on lines 4 and 6 together
    regWrite(8'h9C, 32'h6);
    tick(2);
    lineIn[4] = 1'b1; lineIn[6] = 1'b1;
    expectAt(7, 4, 1'b0, "R8 shared period");
    expectAt(7, 6, 1'b0, "R8 shared period");
    expectAt(8, 4, 1'b1, "R8 shared period");
    expectAt(8, 6, 1'b1, "R8 shared period");
    expectAt(9, 6, 1'b0, "R6 one cycle");
    tick(14);

    // R5 period 0 acts as 1
    regWrite(8'h9C, 32'h0);
    tick(2);
    lineIn[6] = 1'b0;
    expectAt(2, 6, 1'b0, "R5 zero period");
    expectAt(3, 6, 1'b1, "R5 zero period");
    expectAt(4, 6, 1'b0, "R5 zero period");
    tick(10);

    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL R6 watchdog actual=running expected=finished");
      summary();
    end
  end
endmodule